// File: doc/BRIEF.md
# Signed Format Converter and Extender

This block re-encodes a signed integer between three encodings: sign-magnitude, ones' complement and two's complement. The word arrives `IN_W` bits wide with a code for its source encoding. It leaves `OUT_W` bits wide (`OUT_W >= IN_W`) in the encoding chosen by a target code. Each encoding widens by its own rule. Ones' and two's complement copy the top bit upward. Sign-magnitude keeps the sign in the new top bit and pads zeros between the sign and the magnitude.

The conversion itself is combinational. Its result is captured in an output register on the clock edge that sees the input strobe high. The only same-width value that has no sign-magnitude or ones'-complement form is the most negative two's-complement value. That value is flagged as unrepresentable and the output word is forced to zero. Both negative-zero patterns map to zero when the target is two's complement. They stay negative zero in the other two targets.

Top module: `fmt_convert`

## Requirements
- R1: Format codes are 2'b00 sign-magnitude, 2'b01 ones' complement and 2'b10 two's complement. Code 2'b11 behaves exactly like 2'b10, as a source and as a target.
- R2: When the source value fits the target, `word_o` encodes the same integer at `OUT_W` bits in the target encoding.
- R3: A sign-magnitude result carries the sign in bit `OUT_W-1` and the magnitude in the low bits, with zeros in every bit between them.
- R4: When source and target are both ones' complement, or both two's complement, the result is the input pattern with its top bit copied into every added upper bit.
- R5: A negative-zero input (sign-magnitude with only the top bit set, or ones' complement with all bits set) becomes all zeros when the target is two's complement.
- R6: A negative-zero input sent to a sign-magnitude target gives only bit `OUT_W-1` set. Sent to a ones'-complement target, it gives all bits set.
- R7: A two's-complement input with only its top bit set, sent to a sign-magnitude or ones'-complement target with `OUT_W == IN_W`, sets `unrep_o` to 1 and `word_o` to zero.
- R8: `unrep_o` is 0 for every other input, including every conversion that has a two's-complement target.
- R9: `valid_o` is high exactly one cycle after `valid_i` was high. The `word_o` and `unrep_o` of that input appear on the same edge.
- R10: In a cycle with `valid_i` low, `word_o` and `unrep_o` keep their values whatever the other inputs do.
- R11: During reset, `valid_o`, `word_o` and `unrep_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input strobe; the output register loads when high |
| word_i | input | IN_W | Source word |
| src_fmt_i | input | 2 | Source encoding code |
| dst_fmt_i | input | 2 | Target encoding code |
| valid_o | output | 1 | Result valid, one cycle after `valid_i` |
| word_o | output | OUT_W | Converted and widened word |
| unrep_o | output | 1 | The value has no form in the target at `OUT_W` bits |

## Verification
The result of each strobed input (word, flag and valid) is due on the first rising edge after the strobe and not before. A cycle without a strobe must leave the word and flag unchanged at that same edge. The bench drives its inputs on the falling edge and compares every output on the next falling edge. It checks against expectations that a behavioural integer model computed when the stimulus was applied, so each comparison lands exactly one register stage after its stimulus. Two instances run side by side: one widens from 4 to 6 bits, and one keeps 4 bits so the unrepresentable case occurs. Every source value under every pair of codes is swept, and strobe-low cycles with changed inputs are mixed in.

// File: rtl/fmt_conv_pkg.sv
package fmt_conv_pkg;

    // Encoding codes shared by source and target selects
    typedef enum logic [1:0] {
        FMT_SMAG     = 2'b00,
        FMT_ONES     = 2'b01,
        FMT_TWOS     = 2'b10,
        FMT_TWOS_ALT = 2'b11
    } fmt_e;

    // Fold the spare code onto two's complement
    function automatic fmt_e fmt_norm(input logic [1:0] code);
        fmt_e f;
        if (code == 2'b11) f = FMT_TWOS;
        else               f = fmt_e'(code);
        return f;
    endfunction

endpackage

// File: rtl/fmt_decode.sv
// Turns a source word into sign + unsigned magnitude (IN_W bits wide so the
// two's-complement minimum magnitude still fits).
module fmt_decode
    import fmt_conv_pkg::*;
#(
    parameter int IN_W = 8
) (
    input  logic [IN_W-1:0] word_i,
    input  logic [1:0]      fmt_i,
    output logic            neg_o,
    output logic [IN_W-1:0] mag_o,
    output logic            negzero_o
);

    fmt_e fmt;

    always_comb begin
        fmt   = fmt_norm(fmt_i);
        neg_o = word_i[IN_W-1];
        unique case (fmt)
            FMT_SMAG: mag_o = {1'b0, word_i[IN_W-2:0]};
            FMT_ONES: mag_o = neg_o ? ~word_i : word_i;
            default:  mag_o = neg_o ? (~word_i + 1'b1) : word_i;
        endcase
        negzero_o = neg_o && (mag_o == '0);
    end

endmodule

// File: rtl/fmt_mag_widen.sv
// Zero-extends the magnitude to the output width and reports whether it
// exceeds the largest magnitude a sign-magnitude or ones' field can hold.
module fmt_mag_widen #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 12
) (
    input  logic [IN_W-1:0]  mag_i,
    output logic [OUT_W-1:0] mag_o,
    output logic             too_big_o
);

    localparam int PAD_W = OUT_W - IN_W;

    generate
        if (PAD_W > 0) begin : g_wider
            // A magnitude below 2^(IN_W-1)+1 always fits a wider field
            assign mag_o     = {{PAD_W{1'b0}}, mag_i};
            assign too_big_o = 1'b0;
        end else begin : g_same
            // Same width: only 2^(IN_W-1) sets the top bit, and it does not fit
            assign mag_o     = mag_i;
            assign too_big_o = mag_i[IN_W-1];
        end
    endgenerate

endmodule

// File: rtl/fmt_encode.sv
// Builds the target encoding from sign + widened magnitude.
module fmt_encode
    import fmt_conv_pkg::*;
#(
    parameter int OUT_W = 12
) (
    input  logic [1:0]       fmt_i,
    input  logic             neg_i,
    input  logic [OUT_W-1:0] mag_i,
    input  logic             too_big_i,
    output logic [OUT_W-1:0] word_o,
    output logic             unrep_o
);

    fmt_e fmt;

    always_comb begin
        fmt     = fmt_norm(fmt_i);
        unrep_o = 1'b0;
        word_o  = '0;
        unique case (fmt)
            FMT_SMAG: begin
                unrep_o = too_big_i;
                if (!too_big_i) word_o = {neg_i, mag_i[OUT_W-2:0]};
            end
            FMT_ONES: begin
                unrep_o = too_big_i;
                if (!too_big_i) word_o = neg_i ? ~mag_i : mag_i;
            end
            default: begin
                // Negating a zero magnitude gives zero: negative zero folds away
                word_o = neg_i ? (~mag_i + 1'b1) : mag_i;
            end
        endcase
    end

endmodule

// File: rtl/fmt_convert.sv
module fmt_convert
    import fmt_conv_pkg::*;
#(
    parameter int IN_W  = 8,
    parameter int OUT_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             valid_i,
    input  logic [IN_W-1:0]  word_i,
    input  logic [1:0]       src_fmt_i,
    input  logic [1:0]       dst_fmt_i,
    output logic             valid_o,
    output logic [OUT_W-1:0] word_o,
    output logic             unrep_o
);

    localparam logic [IN_W-1:0] TOP_ONLY = {1'b1, {(IN_W-1){1'b0}}};

    typedef struct packed {
        logic             vld;
        logic             unrep;
        logic [OUT_W-1:0] word;
    } state_t;

    state_t state_d, state_q;

    logic             dec_neg;
    logic [IN_W-1:0]  dec_mag;
    logic             dec_negzero;
    logic [OUT_W-1:0] wide_mag;
    logic             wide_too_big;
    logic [OUT_W-1:0] enc_word;
    logic             enc_unrep;

    fmt_decode #(.IN_W(IN_W)) u_decode (
        .word_i    (word_i),
        .fmt_i     (src_fmt_i),
        .neg_o     (dec_neg),
        .mag_o     (dec_mag),
        .negzero_o (dec_negzero)
    );

    fmt_mag_widen #(.IN_W(IN_W), .OUT_W(OUT_W)) u_widen (
        .mag_i     (dec_mag),
        .mag_o     (wide_mag),
        .too_big_o (wide_too_big)
    );

    fmt_encode #(.OUT_W(OUT_W)) u_encode (
        .fmt_i     (dst_fmt_i),
        .neg_i     (dec_neg),
        .mag_i     (wide_mag),
        .too_big_i (wide_too_big),
        .word_o    (enc_word),
        .unrep_o   (enc_unrep)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = valid_i;
        if (valid_i) begin
            state_d.word  = enc_word;
            state_d.unrep = enc_unrep;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign valid_o = state_q.vld;
    assign word_o  = state_q.word;
    assign unrep_o = state_q.unrep;

    // Checks at the block boundary
    AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_i |=> valid_o); // R9
    AST_VALID_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni) !valid_i |=> !valid_o); // R9
    AST_HOLD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni) !valid_i |=> ($stable(word_o) && $stable(unrep_o))); // R10
    AST_UNREP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni) unrep_o |-> (word_o == '0)); // R7
    AST_TWOS_NO_UNREP: assert property (@(posedge clk_i) disable iff (!rst_ni) (valid_i && fmt_norm(dst_fmt_i) == FMT_TWOS) |=> !unrep_o); // R8
    AST_NEGZERO_TWOS: assert property (@(posedge clk_i) disable iff (!rst_ni) (valid_i && dec_negzero && dst_fmt_i[1]) |=> (word_o == '0)); // R5
    AST_SMAG_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni) (valid_i && !unrep_o && src_fmt_i == 2'b00 && dst_fmt_i == 2'b00) |=> (word_o[OUT_W-1] == $past(word_i[IN_W-1]))); // R3
    AST_TWOS_MIN_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni) (valid_i && OUT_W == IN_W && src_fmt_i[1] && word_i == TOP_ONLY && !dst_fmt_i[1]) |=> unrep_o); // R7

endmodule

// File: tb/fmt_convert_tb.sv
`timescale 1ns/100ps
module fmt_convert_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       valid = 1'b0;
    logic [3:0] word = '0;
    logic [1:0] src = '0;
    logic [1:0] dst = '0;

    logic       vld6, unrep6, vld4, unrep4;
    logic [5:0] word6;
    logic [3:0] word4;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Expected register contents after the next rising edge
    int    exp_vld = 0;
    int    exp_w6 = 0, exp_w4 = 0;
    int    exp_u6 = 0, exp_u4 = 0;
    string tag6 = "R11", tag4 = "R11", utag6 = "R11", utag4 = "R11", vtag = "R11";

    always #2.5 clk = ~clk;

    fmt_convert #(.IN_W(4), .OUT_W(6)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .word_i(word),
        .src_fmt_i(src), .dst_fmt_i(dst),
        .valid_o(vld6), .word_o(word6), .unrep_o(unrep6)
    );

    fmt_convert #(.IN_W(4), .OUT_W(4)) u_dut_eq (
        .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .word_i(word),
        .src_fmt_i(src), .dst_fmt_i(dst),
        .valid_o(vld4), .word_o(word4), .unrep_o(unrep4)
    );

    // Behavioural model: source pattern -> integer -> target pattern at w bits
    function automatic void ref_conv(input int d, input int s, input int t, input int w,
                                     output int ow, output int ou);
        int  v, mx, s2, t2;
        bit  nz, neg;
        s2 = (s == 3) ? 2 : s;
        t2 = (t == 3) ? 2 : t;
        neg = (d >= 8);
        nz = 0;
        case (s2)
            0: begin v = neg ? -(d - 8) : d; nz = (d == 8); end
            1: begin v = neg ? -(15 - d) : d; nz = (d == 15); end
            default: v = neg ? d - 16 : d;
        endcase
        mx = (1 << (w - 1)) - 1;
        ou = 0;
        if (t2 != 2 && v < -mx) begin
            ou = 1; ow = 0;
        end else if (nz) begin
            if (t2 == 0)      ow = 1 << (w - 1);
            else if (t2 == 1) ow = (1 << w) - 1;
            else              ow = 0;
        end else if (v >= 0) begin
            ow = v;
        end else begin
            case (t2)
                0: ow = (1 << (w - 1)) + (-v);
                1: ow = ((1 << w) - 1) - (-v);
                default: ow = (1 << w) + v;
            endcase
        end
    endfunction

    function automatic string tag_of(input int d, input int s, input int t, input int w);
        bit nz, tmin;
        nz   = (s == 0 && d == 8) || (s == 1 && d == 15);
        tmin = (s >= 2 && d == 8);
        if (tmin && t < 2 && w == 4) return "R7";
        if (nz && t >= 2)            return "R5";
        if (nz)                      return "R6";
        if (s == 3 || t == 3)        return "R1";
        if (t == 0 && w > 4)         return "R3";
        if (s == t && s > 0 && w > 4) return "R4";
        return "R2";
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all();
        chk(vtag, "valid6", int'(vld6), exp_vld);
        chk(vtag, "valid4", int'(vld4), exp_vld);
        chk(tag6, "word6", int'(word6), exp_w6);
        chk(utag6, "unrep6", int'(unrep6), exp_u6);
        chk(tag4, "word4", int'(word4), exp_w4);
        chk(utag4, "unrep4", int'(unrep4), exp_u4);
    endtask

    task automatic step(input bit v, input int d, input int s, input int t);
        int w, u;
        @(negedge clk);
        check_all();
        valid = v; word = d[3:0]; src = s[1:0]; dst = t[1:0];
        vtag = "R9";
        if (v) begin
            exp_vld = 1;
            ref_conv(d, s, t, 6, w, u); exp_w6 = w; exp_u6 = u;
            tag6 = tag_of(d, s, t, 6); utag6 = (tag6 == "R7") ? "R7" : "R8";
            ref_conv(d, s, t, 4, w, u); exp_w4 = w; exp_u4 = u;
            tag4 = tag_of(d, s, t, 4); utag4 = (tag4 == "R7") ? "R7" : "R8";
        end else begin
            exp_vld = 0;
            tag6 = "R10"; tag4 = "R10"; utag6 = "R10"; utag4 = "R10";
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R11: outputs zero while reset is held
        repeat (3) @(negedge clk);
        check_all();
        rst_n = 1'b1;
        for (int s = 0; s < 4; s++) begin
            for (int t = 0; t < 4; t++) begin
                for (int d = 0; d < 16; d++) begin
                    step(1'b1, d, s, t);
                    if ((d % 5) == 4) step(1'b0, d ^ 5, 3 - s, 3 - t); // R10 hold
                end
            end
        end
        step(1'b0, 8, 2, 0);
        step(1'b0, 15, 1, 2);
        @(negedge clk);
        check_all();
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule